// File: doc/BRIEF.md
# Two-Stage Output Combiner with Background Interstage Gain Tracking

This block forms the final output word of a two-stage converter. The first stage is an 8-bit successive-approximation quantizer. Its residue is digitized by a ring-oscillator stage, whose differentiated count is passed in here. The block weights the coarse code by the fine-stage resolution. It multiplies the fine count by a learned interstage gain and adds the two, so the coarse stage's quantization and comparator errors cancel.

The interstage gain drifts with process, voltage and temperature, so it is tracked while the converter runs. A 15-bit maximal-length shift register produces a one-bit pseudo-random dither, which is sent to one extra unit capacitor in the first stage. The known dither contribution is removed from the scaled fine output. The remainder is correlated with the dither sign, and that correlation steps the gain coefficient. The coarse quantizer resolves 8 bits, so little coarse error masks the dither, and the estimate settles quickly.

Top module: `mash_gain_combiner`

## Requirements
- R1: While rst_ni is low, gain_o equals the nominal gain 4096 (1.0 with 12 fractional bits), out_valid_o is 0, out_data_o is 0, and dither_o shows the most significant bit of the seed (default seed 1, so dither_o is 0).
- R2: dither_o is bit 14 of a 15-bit shift register. On each cycle with valid_i high, the register shifts towards its top bit, and bit 14 XOR bit 13 enters bit 0. With valid_i low it holds.
- R3: For each sample, out_data_o equals sar*64 + floor(g*fine/4096) - s*64. Here g is gain_o in the cycle the sample is accepted, fine is the signed count, and s is +1 when the dither bit paired with the sample is 1 and -1 when it is 0.
- R4: A sample presented with valid_i high at one rising edge produces out_valid_o high for exactly the cycle after the next rising edge. Gaps in valid_i produce matching gaps in out_valid_o.
- R5: When a sample reaches the output with cal_en_i high, gain_o becomes g - ((s*e) >>> mu_i) at that same edge, where e = floor(g*fine/4096) - s*64. The shift is arithmetic, so it rounds towards minus infinity.
- R6: While cal_en_i is low, gain_o does not change, and the output still uses the frozen gain.
- R7: The gain update saturates at 0 and 65535 instead of wrapping.
- R8: Each sample pairs with the value dither_o shows in the cycle it is accepted. A sample accepted back to back with the previous one uses the gain from before that previous sample's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Coarse code and fine count present a new sample |
| sar_i | input | 8 | Unsigned coarse code |
| fine_i | input | 8 | Signed differentiated fine count |
| cal_en_i | input | 1 | Enables gain tracking; low freezes the gain |
| mu_i | input | 4 | Step-size shift for the gain update |
| dither_o | output | 1 | Dither bit for the extra first-stage capacitor |
| out_valid_o | output | 1 | out_data_o holds a new combined sample |
| out_data_o | output | 17 | Signed combined output |
| gain_o | output | 16 | Current gain, unsigned, 12 fractional bits |

## Verification
The assertions assume valid_i, cal_en_i and mu_i are free of unknowns from reset release onward. They also assume one gain step cannot move the coefficient across half its range. The second holds because the fine count is 8 bits, which bounds the error term near 2100. The stimulus drives every input from a defined value at a falling edge. It includes a phase with mu_i at zero and the fine count pinned against the dither sign, which drives the gain into its upper limit. No legal fine count can pull the gain down to zero, so the lower limit is covered only by the saturation logic's assertion.

// File: rtl/mash_pkg.sv
package mash_pkg;
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mash_dither_lfsr.sv
module mash_dither_lfsr #(
  parameter int unsigned LEN    = 15,
  parameter int unsigned TAP_HI = 14,
  parameter int unsigned TAP_LO = 13,
  parameter logic [LEN-1:0] SEED = {{(LEN-1){1'b0}}, 1'b1}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic dither_o
);
  logic [LEN-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= SEED;
    else if (step_i) st_q <= {st_q[LEN-2:0], st_q[TAP_HI] ^ st_q[TAP_LO]};
  end

  assign dither_o = st_q[LEN-1];

  assert_lfsr_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  assert_lfsr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(st_q));
endmodule

// File: rtl/mash_fine_scaler.sv
module mash_fine_scaler #(
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  parameter int FINE_W    = 8,
  parameter int SAR_W     = 8,
  localparam int PROD_W   = GAIN_W + 1 + FINE_W,
  localparam int SC_W     = PROD_W - GAIN_FRAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [SAR_W-1:0]         sar_i,
  input  logic signed [FINE_W-1:0] fine_i,
  input  logic                     dither_i,
  input  logic [GAIN_W-1:0]        gain_i,
  output logic                     v_o,
  output logic [SAR_W-1:0]         sar_o,
  output logic signed [SC_W-1:0]   sc_o,
  output logic                     d_o
);
  logic signed [PROD_W-1:0] prod;
  logic signed [SC_W-1:0]   sc_d;

  assign prod = PROD_W'($signed({1'b0, gain_i})) * PROD_W'(fine_i);
  assign sc_d = SC_W'(prod >>> GAIN_FRAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      sar_o <= '0;
      sc_o  <= '0;
      d_o   <= 1'b0;
    end else begin
      v_o <= valid_i;
      if (valid_i) begin
        sar_o <= sar_i;
        sc_o  <= sc_d;
        d_o   <= dither_i;
      end
    end
  end

  assert_stage_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> v_o);
  assert_stage_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !v_o);
endmodule

// File: rtl/mash_gain_cal.sv
module mash_gain_cal #(
  parameter int GAIN_W = 16,
  parameter int SC_W   = 13,
  parameter int LSB_SH = 6,
  parameter int MU_W   = 4,
  parameter logic [GAIN_W-1:0] G_NOM = 16'h1000,
  localparam int E_W   = mash_pkg::max2(SC_W, LSB_SH + 2) + 1,
  localparam int ACC_W = mash_pkg::max2(GAIN_W, E_W) + 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   v_i,
  input  logic signed [SC_W-1:0] sc_i,
  input  logic                   d_i,
  input  logic                   cal_en_i,
  input  logic [MU_W-1:0]        mu_i,
  output logic [GAIN_W-1:0]      gain_o
);
  localparam logic signed [E_W-1:0]   W_S   = E_W'(1 << LSB_SH);
  localparam logic signed [ACC_W-1:0] G_MAX = {{(ACC_W-GAIN_W){1'b0}}, {GAIN_W{1'b1}}};

  logic signed [E_W-1:0]   err;
  logic signed [E_W:0]     corr_full, corr;
  logic signed [ACC_W-1:0] acc;
  logic [GAIN_W-1:0]       gain_q, gain_d;

  assign err       = E_W'(sc_i) - (d_i ? W_S : -W_S);
  assign corr_full = d_i ? (E_W+1)'(err) : -((E_W+1)'(err));
  assign corr      = corr_full >>> mu_i;
  assign acc       = $signed(ACC_W'(gain_q)) - ACC_W'(corr);

  always_comb begin
    if (acc < 0)          gain_d = '0;
    else if (acc > G_MAX) gain_d = '1;
    else                  gain_d = acc[GAIN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gain_q <= G_NOM;
    else if (v_i && cal_en_i) gain_q <= gain_d;
  end

  assign gain_o = gain_q;

  assert_gain_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_en_i |=> $stable(gain_q));
  assert_gain_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> $stable(gain_q));
  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(gain_q[GAIN_W-1]) && $past(gain_q[GAIN_W-2]) &&
      !gain_q[GAIN_W-1] && !gain_q[GAIN_W-2]));
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$past(gain_q[GAIN_W-1]) && !$past(gain_q[GAIN_W-2]) &&
      gain_q[GAIN_W-1] && gain_q[GAIN_W-2]));
endmodule

// File: rtl/mash_gain_combiner.sv
module mash_gain_combiner #(
  parameter int SAR_W     = 8,
  parameter int FINE_W    = 8,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  parameter int LSB_SH    = 6,
  parameter int MU_W      = 4,
  parameter int LFSR_LEN  = 15,
  parameter logic [GAIN_W-1:0]   G_NOM     = 16'h1000,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = 15'h0001,
  localparam int SC_W     = GAIN_W + 1 + FINE_W - GAIN_FRAC,
  localparam int OUT_W    = mash_pkg::max2(SAR_W + LSB_SH, SC_W) + 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [SAR_W-1:0]         sar_i,
  input  logic signed [FINE_W-1:0] fine_i,
  input  logic                     cal_en_i,
  input  logic [MU_W-1:0]          mu_i,
  output logic                     dither_o,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  out_data_o,
  output logic [GAIN_W-1:0]        gain_o
);
  localparam logic signed [OUT_W-1:0] W_O = OUT_W'(1 << LSB_SH);

  logic                   v1, d1;
  logic [SAR_W-1:0]       sar1;
  logic signed [SC_W-1:0] sc1;
  logic signed [OUT_W-1:0] coarse, sum;

  mash_dither_lfsr #(
    .LEN(LFSR_LEN), .TAP_HI(LFSR_LEN-1), .TAP_LO(LFSR_LEN-2), .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(valid_i), .dither_o(dither_o)
  );

  mash_fine_scaler #(
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .FINE_W(FINE_W), .SAR_W(SAR_W)
  ) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sar_i(sar_i),
    .fine_i(fine_i), .dither_i(dither_o), .gain_i(gain_o),
    .v_o(v1), .sar_o(sar1), .sc_o(sc1), .d_o(d1)
  );

  mash_gain_cal #(
    .GAIN_W(GAIN_W), .SC_W(SC_W), .LSB_SH(LSB_SH), .MU_W(MU_W), .G_NOM(G_NOM)
  ) u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .v_i(v1), .sc_i(sc1), .d_i(d1),
    .cal_en_i(cal_en_i), .mu_i(mu_i), .gain_o(gain_o)
  );

  assign coarse = $signed(OUT_W'({sar1, {LSB_SH{1'b0}}}));
  assign sum    = coarse + OUT_W'(sc1) - (d1 ? W_O : -W_O);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= v1;
      if (v1) out_data_o <= sum;
    end
  end

  assert_out_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 |=> out_valid_o);
  assert_out_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1 |=> !out_valid_o);
  assert_data_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

// File: tb/sim_mash_gain_combiner.sv
module sim_mash_gain_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] sar_i = '0;
  logic signed [7:0] fine_i = '0;
  logic cal_en_i = 1'b0;
  logic [3:0] mu_i = 4'd6;
  logic dither_o, out_valid_o;
  logic signed [16:0] out_data_o;
  logic [15:0] gain_o;

  int n_vec = 0, n_bad = 0;
  string gtag = "R5", dtag = "R3";

  int m_lfsr, m_g, m_v1, m_sar1, m_sc1, m_d1, m_ov, m_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  mash_gain_combiner u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sar_i(sar_i), .fine_i(fine_i),
    .cal_en_i(cal_en_i), .mu_i(mu_i), .dither_o(dither_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .gain_o(gain_o)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lfsr = 1; m_g = 4096; m_v1 = 0; m_sar1 = 0; m_sc1 = 0; m_d1 = 0; m_ov = 0; m_y = 0;
    end else begin
      int n_ov, n_y, n_g, s, e, c, t;
      n_ov = m_v1; n_y = m_y; n_g = m_g;
      if (m_v1 != 0) begin
        s = (m_d1 != 0) ? 1 : -1;
        n_y = m_sar1 * 64 + m_sc1 - s * 64;
        e = m_sc1 - s * 64;
        c = (s * e) >>> int'(mu_i);
        t = m_g - c;
        if (t < 0) t = 0;
        if (t > 65535) t = 65535;
        if (cal_en_i) n_g = t;
      end
      if (valid_i) begin
        m_sc1 = (m_g * int'(fine_i)) >>> 12;
        m_sar1 = int'(sar_i);
        m_d1 = (m_lfsr >> 14) & 1;
        m_lfsr = ((m_lfsr << 1) & 32767) | (((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1);
        m_v1 = 1;
      end else m_v1 = 0;
      m_ov = n_ov; m_y = n_y; m_g = n_g;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 out_valid", int'(out_valid_o), m_ov);
    chk({dtag, " out_data"}, int'(out_data_o), m_y);
    chk({gtag, " gain"}, int'(gain_o), m_g);
    chk("R2 dither", int'(dither_o), (m_lfsr >> 14) & 1);
  endtask

  // one cycle: check at falling edge, then drive the next sample
  task automatic cyc(input bit v, input int fine_mode, input int pct);
    int s;
    @(negedge clk);
    compare_all();
    s = (((m_lfsr >> 14) & 1) != 0) ? 1 : -1;
    valid_i = v && ($urandom_range(99) < pct);
    sar_i = 8'($urandom_range(255));
    case (fine_mode)
      0: fine_i = 8'(s * 48 + $signed($urandom_range(40)) - 20);
      1: fine_i = 8'(-s * 127);
      2: fine_i = 8'(s * 127);
      default: fine_i = 8'($urandom_range(255));
    endcase
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 gain", int'(gain_o), 4096);
      chk("R1 out_valid", int'(out_valid_o), 0);
      chk("R1 out_data", int'(out_data_o), 0);
      chk("R1 dither", int'(dither_o), 0);
    end
    @(negedge clk); rst_ni = 1'b1;
    cal_en_i = 1'b1;
    // R2 hold with no samples
    for (int i = 0; i < 4; i++) cyc(1'b0, 0, 0);
    // R5/R8: back-to-back tracking
    mu_i = 4'd6; gtag = "R5"; dtag = "R8";
    for (int i = 0; i < 600; i++) cyc(1'b1, 0, 100);
    // R4/R3: gapped samples, faster step
    mu_i = 4'd3; dtag = "R3";
    for (int i = 0; i < 400; i++) cyc(1'b1, 3, 50);
    // R6: frozen gain
    cal_en_i = 1'b0; gtag = "R6";
    for (int i = 0; i < 300; i++) cyc(1'b1, 1, 80);
    // R7: drive to upper limit, then recover
    cal_en_i = 1'b1; mu_i = 4'd0; gtag = "R7";
    for (int i = 0; i < 500; i++) cyc(1'b1, 1, 100);
    @(negedge clk);
    chk("R7 upper limit", int'(gain_o), 65535);
    for (int i = 0; i < 200; i++) cyc(1'b1, 2, 100);
    for (int i = 0; i < 4; i++) cyc(1'b0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule